// File: doc/BRIEF.md
# Video Register Port and Address Mapper

This block is the processor side of a tile-based video generator. A host selects one of eight register slots with a 3-bit index, a chip select and separate read and write strobes. Through these slots it sets the control and mask bytes and the sprite-memory address. It loads scroll and address values with two writes each through one shared toggle, and it moves bytes to and from video memory and sprite memory. Read data appears in the same cycle as the read strobe.

The video address pointer picks one of three memory regions. The low 8 KB is read-only pattern memory. The range above it, up to the palette window, is nametable RAM, and its table index is folded according to a mirroring mode. The top window is palette RAM, reduced to 32 entries, and the four sprite backdrop entries land on their background twins. The block only shapes addresses and strobes. The memories sit outside and answer reads combinationally. The vertical-blank flag lives here, while the renderer supplies the sprite flags.

Top module: `vid_reg_port`

## Requirements
- R1: While reset is held, and after it is released, the control byte, mask byte, fine X, pointer, sprite address and vertical-blank flag are all zero, and the shared write toggle is cleared.
- R2: An access takes effect only when chip select is high. Slot map: 0 control (write), 1 mask (write), 2 status (read), 3 sprite address (write), 4 sprite data (read/write), 5 scroll (write), 6 address (write), 7 data (read/write). Reading a write-only slot returns 0.
- R3: A first scroll write sets fine X from data[2:0] and pointer[4:0] from data[7:3]. A second scroll write sets pointer[9:5] from data[7:3], pointer[11] from data[7] and pointer[14:12] from data[2:0], and leaves every other pointer bit alone. The pointer is 15 bits wide.
- R4: A first address write sets the pointer to data[5:0] placed at bits 13:8, with every other bit zero. A second address write ORs the data into pointer[7:0].
- R5: Scroll and address writes share one toggle, and each such write flips it. A status read clears it.
- R6: Each data-slot read or write advances the pointer by 32 when control bit 2 is 1, and by 1 otherwise. The result is kept to 14 bits, so pointer bit 14 becomes 0.
- R7: With a = pointer[13:0], memSel is 0 (pattern) for a < 0x2000, 2 (palette) for a >= 0x3F00, and 1 (nametable) otherwise. memWe is high only for a data-slot write whose memSel is not pattern.
- R8: Nametable address, where t = a[11:10] and o = a[9:0]: mode 0 gives t[1]*0x400+o, mode 1 gives t[0]*0x400+o, mode 2 gives o, mode 3 gives 0x400+o, and modes 4 to 7 give a[11:0].
- R9: Palette address is a[4:0], with bit 4 cleared when a[4] is 1 and a[1:0] is 0.
- R10: A status read returns {vblank, sprZeroHit, sprOverflow, 5'b0} and clears vblank. vblankSet sets the flag and has priority over both the status-read clear and vblankClr.
- R11: A sprite-data write drives oamWe with the current sprite address and then increments that address by 1, wrapping at 8 bits. A sprite-data read leaves the address unchanged.
- R12: In the cycle of the read strobe, a data-slot read returns memRdata for the mapped address, and a sprite-data read returns oamRdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regSel | input | 3 | Register slot index |
| regCs | input | 1 | Chip select |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, valid in the strobe cycle |
| mirrorMode | input | 3 | Nametable mirroring mode |
| vblankSet | input | 1 | Pulse that sets the vertical-blank flag |
| vblankClr | input | 1 | Pulse that clears the vertical-blank flag |
| sprZeroHit | input | 1 | Sprite-zero hit flag from the renderer |
| sprOverflow | input | 1 | Sprite overflow flag from the renderer |
| ctrlOut | output | 8 | Control byte |
| maskOut | output | 8 | Mask byte |
| fineX | output | 3 | Fine horizontal scroll |
| vramPtr | output | 15 | Video address pointer |
| memSel | output | 2 | Target region: 0 pattern, 1 nametable, 2 palette |
| memAddr | output | 14 | Mapped address inside the region |
| memWe | output | 1 | Video memory write enable |
| memRe | output | 1 | Video memory read strobe |
| memWdata | output | 8 | Video memory write data |
| memRdata | input | 8 | Video memory read data (combinational) |
| oamAddr | output | 8 | Sprite memory address |
| oamWe | output | 1 | Sprite memory write enable |
| oamWdata | output | 8 | Sprite memory write data |
| oamRdata | input | 8 | Sprite memory read data (combinational) |

## Verification
The bench builds the block with its default parameters: a 14-bit address, a wide step of 32 and an 8-bit sprite address. These sizes are small enough that random traffic reaches the 0x3FFF-to-0 wrap of the pointer, the 255-to-0 wrap of the sprite address, and all three memory regions under every mirroring mode. Directed cases pin down the palette alias entries, each mirroring mode at a fixed nametable address, and the collision between a status read and a vertical-blank set.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  typedef enum logic [1:0] {
    SEL_PATTERN   = 2'd0,
    SEL_NAMETABLE = 2'd1,
    SEL_PALETTE   = 2'd2
  } memSelE;

  localparam logic [2:0] SLOT_CTRL    = 3'd0;
  localparam logic [2:0] SLOT_MASK    = 3'd1;
  localparam logic [2:0] SLOT_STATUS  = 3'd2;
  localparam logic [2:0] SLOT_OAMADDR = 3'd3;
  localparam logic [2:0] SLOT_OAMDATA = 3'd4;
  localparam logic [2:0] SLOT_SCROLL  = 3'd5;
  localparam logic [2:0] SLOT_ADDR    = 3'd6;
  localparam logic [2:0] SLOT_DATA    = 3'd7;

  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic rdStatus;
    logic wrOamAddr;
    logic wrOamData;
    logic rdOamData;
    logic wrScroll;
    logic wrAddr;
    logic wrData;
    logic rdData;
  } strobeS;
endpackage

// File: rtl/vrp_ctrl.sv
module vrp_ctrl
  import vrp_pkg::*;
(
  input  logic [2:0] regSel,
  input  logic       regCs,
  input  logic       regRd,
  input  logic       regWr,
  output strobeS     strobes
);
  logic wrEn;
  logic rdEn;

  always_comb begin
    wrEn = regCs && regWr;
    rdEn = regCs && regRd;
    strobes           = '0;
    strobes.wrCtrl    = wrEn && (regSel == SLOT_CTRL);
    strobes.wrMask    = wrEn && (regSel == SLOT_MASK);
    strobes.rdStatus  = rdEn && (regSel == SLOT_STATUS);
    strobes.wrOamAddr = wrEn && (regSel == SLOT_OAMADDR);
    strobes.wrOamData = wrEn && (regSel == SLOT_OAMDATA);
    strobes.rdOamData = rdEn && (regSel == SLOT_OAMDATA);
    strobes.wrScroll  = wrEn && (regSel == SLOT_SCROLL);
    strobes.wrAddr    = wrEn && (regSel == SLOT_ADDR);
    strobes.wrData    = wrEn && (regSel == SLOT_DATA);
    strobes.rdData    = rdEn && (regSel == SLOT_DATA);
  end
endmodule

// File: rtl/vrp_datapath.sv
module vrp_datapath
  import vrp_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int WIDE_STEP = 32,
  parameter int OAM_AW    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobeS            strobes,
  input  logic [7:0]        wdata,
  input  logic              vblankSet,
  input  logic              vblankClr,
  output logic [7:0]        ctrlReg,
  output logic [7:0]        maskReg,
  output logic [OAM_AW-1:0] oamAddr,
  output logic [2:0]        fineX,
  output logic [ADDR_W:0]   ptr,
  output logic              vblank
);
  localparam int PTR_W = ADDR_W + 1;

  logic              toggle;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] nextLow;

  always_comb begin
    step    = ctrlReg[2] ? ADDR_W'(WIDE_STEP) : ADDR_W'(1);
    nextLow = ptr[ADDR_W-1:0] + step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg <= '0;
      maskReg <= '0;
      oamAddr <= '0;
      fineX   <= '0;
      ptr     <= '0;
      toggle  <= 1'b0;
      vblank  <= 1'b0;
    end else begin
      if (strobes.wrCtrl)    ctrlReg <= wdata;
      if (strobes.wrMask)    maskReg <= wdata;
      if (strobes.wrOamAddr) oamAddr <= wdata[OAM_AW-1:0];
      if (strobes.wrOamData) oamAddr <= oamAddr + 1'b1;
      if (strobes.wrScroll) begin
        if (!toggle) begin
          fineX    <= wdata[2:0];
          ptr[4:0] <= wdata[7:3];
        end else begin
          ptr[9:5]   <= wdata[7:3];
          ptr[11]    <= wdata[7];
          ptr[14:12] <= wdata[2:0];
        end
        toggle <= !toggle;
      end
      if (strobes.wrAddr) begin
        if (!toggle) ptr <= PTR_W'({wdata[5:0], 8'h00});
        else         ptr[7:0] <= ptr[7:0] | wdata;
        toggle <= !toggle;
      end
      if (strobes.wrData || strobes.rdData) ptr <= {1'b0, nextLow};
      if (strobes.rdStatus) toggle <= 1'b0;
      if (vblankSet) vblank <= 1'b1;
      else if (vblankClr || strobes.rdStatus) vblank <= 1'b0;
    end
  end

  // R5
  toggle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.rdStatus |=> !toggle);
  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.wrData || strobes.rdData) |=> !ptr[ADDR_W]);
  // R11
  oam_inc_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.wrOamData |=> oamAddr == OAM_AW'($past(oamAddr) + 1'b1));
  // R11
  oam_hold_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.rdOamData |=> $stable(oamAddr));
  // R10
  vblank_set_chk: assert property (@(posedge clk) disable iff (rst)
    vblankSet |=> vblank);
endmodule

// File: rtl/vrp_mapper.sv
module vrp_mapper
  import vrp_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [2:0]        mirrorMode,
  output memSelE            sel,
  output logic [ADDR_W-1:0] mapped
);
  logic [1:0]  tbl;
  logic [9:0]  off;
  logic [11:0] ntAddr;
  logic [4:0]  palAddr;

  always_comb begin
    tbl     = addrIn[11:10];
    off     = addrIn[9:0];
    ntAddr  = addrIn[11:0];
    palAddr = addrIn[4:0];
    case (mirrorMode)
      3'd0:    ntAddr = {1'b0, tbl[1], off};
      3'd1:    ntAddr = {1'b0, tbl[0], off};
      3'd2:    ntAddr = {2'b00, off};
      3'd3:    ntAddr = {2'b01, off};
      default: ntAddr = addrIn[11:0];
    endcase
    if (palAddr[4] && (palAddr[1:0] == 2'b00)) palAddr[4] = 1'b0;
    if (!addrIn[13]) begin
      sel    = SEL_PATTERN;
      mapped = addrIn;
    end else if (addrIn[13:8] == 6'h3F) begin
      sel    = SEL_PALETTE;
      mapped = ADDR_W'(palAddr);
    end else begin
      sel    = SEL_NAMETABLE;
      mapped = ADDR_W'(ntAddr);
    end
  end
endmodule

// File: rtl/vid_reg_port.sv
module vid_reg_port
  import vrp_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int WIDE_STEP = 32,
  parameter int OAM_AW    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        regSel,
  input  logic              regCs,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic [2:0]        mirrorMode,
  input  logic              vblankSet,
  input  logic              vblankClr,
  input  logic              sprZeroHit,
  input  logic              sprOverflow,
  output logic [7:0]        ctrlOut,
  output logic [7:0]        maskOut,
  output logic [2:0]        fineX,
  output logic [ADDR_W:0]   vramPtr,
  output logic [1:0]        memSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic              memRe,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic [OAM_AW-1:0] oamAddr,
  output logic              oamWe,
  output logic [7:0]        oamWdata,
  input  logic [7:0]        oamRdata
);
  strobeS strobes;
  memSelE selE;
  logic   vblank;

  vrp_ctrl ctrl_i (
    .regSel (regSel),
    .regCs  (regCs),
    .regRd  (regRd),
    .regWr  (regWr),
    .strobes(strobes)
  );

  vrp_datapath #(.ADDR_W(ADDR_W), .WIDE_STEP(WIDE_STEP), .OAM_AW(OAM_AW)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .wdata    (regWdata),
    .vblankSet(vblankSet),
    .vblankClr(vblankClr),
    .ctrlReg  (ctrlOut),
    .maskReg  (maskOut),
    .oamAddr  (oamAddr),
    .fineX    (fineX),
    .ptr      (vramPtr),
    .vblank   (vblank)
  );

  vrp_mapper #(.ADDR_W(ADDR_W)) map_i (
    .addrIn    (vramPtr[ADDR_W-1:0]),
    .mirrorMode(mirrorMode),
    .sel       (selE),
    .mapped    (memAddr)
  );

  always_comb begin
    memSel   = selE;
    memWe    = strobes.wrData && (selE != SEL_PATTERN);
    memRe    = strobes.rdData;
    memWdata = regWdata;
    oamWe    = strobes.wrOamData;
    oamWdata = regWdata;
    regRdata = '0;
    if (strobes.rdStatus)  regRdata = {vblank, sprZeroHit, sprOverflow, 5'b0};
    if (strobes.rdOamData) regRdata = oamRdata;
    if (strobes.rdData)    regRdata = memRdata;
  end

  // R7
  pattern_ro_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |-> memSel != 2'd0);
  // R9
  pal_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (memSel == 2'd2) |-> !(memAddr[4] && memAddr[1:0] == 2'b00));
endmodule

// File: tb/vid_reg_port_tb.sv
`timescale 1ns/1ps
module vid_reg_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] regSel = '0;
  logic regCs = 0, regRd = 0, regWr = 0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [2:0] mirrorMode = '0;
  logic vblankSet = 0, vblankClr = 0, sprZeroHit = 0, sprOverflow = 0;
  logic [7:0] ctrlOut, maskOut;
  logic [2:0] fineX;
  logic [14:0] vramPtr;
  logic [1:0] memSel;
  logic [13:0] memAddr;
  logic memWe, memRe;
  logic [7:0] memWdata, memRdata;
  logic [7:0] oamAddr;
  logic oamWe;
  logic [7:0] oamWdata, oamRdata;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  logic [7:0]  mCtrl = 0, mMask = 0, mOam = 0;
  logic [2:0]  mFineX = 0;
  logic [14:0] mPtr = 0;
  bit mToggle = 0, mVbl = 0;

  always #2.5 clk = ~clk;

  assign memRdata = memAddr[7:0] ^ {memAddr[13:8], memSel};
  assign oamRdata = oamAddr ^ 8'hA5;

  vid_reg_port dut_i (
    .clk(clk), .rst(rst), .regSel(regSel), .regCs(regCs), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .mirrorMode(mirrorMode),
    .vblankSet(vblankSet), .vblankClr(vblankClr), .sprZeroHit(sprZeroHit),
    .sprOverflow(sprOverflow), .ctrlOut(ctrlOut), .maskOut(maskOut), .fineX(fineX),
    .vramPtr(vramPtr), .memSel(memSel), .memAddr(memAddr), .memWe(memWe), .memRe(memRe),
    .memWdata(memWdata), .memRdata(memRdata), .oamAddr(oamAddr), .oamWe(oamWe),
    .oamWdata(oamWdata), .oamRdata(oamRdata)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // returns {sel[1:0], addr[13:0]}
  function automatic logic [15:0] expMap(input logic [14:0] p, input logic [2:0] mode);
    int a, n, t, o, r, q;
    a = int'(p) % 16384;
    if (a < 'h2000) return {2'd0, 14'(a)};
    if (a >= 'h3F00) begin
      q = a % 32;
      if (q >= 16 && q % 4 == 0) q = q - 16;
      return {2'd2, 14'(q)};
    end
    n = (a - 'h2000) % 4096;
    t = n / 1024;
    o = n % 1024;
    case (mode)
      3'd0: r = (t < 2) ? o : o + 1024;
      3'd1: r = (t % 2) * 1024 + o;
      3'd2: r = o;
      3'd3: r = o + 1024;
      default: r = n;
    endcase
    return {2'd1, 14'(r)};
  endfunction

  function automatic logic [7:0] expMem(input logic [15:0] m);
    return m[7:0] ^ {m[13:8], m[15:14]};
  endfunction

  function automatic logic [14:0] stepPtr(input logic [14:0] p, input logic [7:0] c);
    int v;
    v = (int'(p) % 16384 + (c[2] ? 32 : 1)) % 16384;
    return 15'(v);
  endfunction

  task automatic finishCycle();
    @(posedge clk);
    @(negedge clk);
    regCs = 0; regRd = 0; regWr = 0;
    vblankSet = 0; vblankClr = 0;
  endtask

  task automatic wrReg(input logic [2:0] s, input logic [7:0] d);
    logic [15:0] m;
    regSel = s; regWdata = d; regCs = 1; regWr = 1;
    #1;
    if (s == 3'd7) begin
      m = expMap(mPtr, mirrorMode);
      chk("R7 memSel on data write", memSel, m[15:14]);
      chk("R7 memWe on data write", memWe, m[15:14] != 2'd0);
      if (m[15:14] != 2'd0) chk("R8/R9 mapped write address", memAddr, m[13:0]);
    end
    if (s == 3'd4) begin
      chk("R11 oamWe on sprite write", oamWe, 1);
      chk("R11 sprite write address", oamAddr, mOam);
    end
    finishCycle();
    case (s)
      3'd0: mCtrl = d;
      3'd1: mMask = d;
      3'd3: mOam = d;
      3'd4: mOam = mOam + 8'd1;
      3'd5: begin
        if (!mToggle) begin mFineX = d[2:0]; mPtr[4:0] = d[7:3]; end
        else begin mPtr[9:5] = d[7:3]; mPtr[11] = d[7]; mPtr[14:12] = d[2:0]; end
        mToggle = !mToggle;
      end
      3'd6: begin
        if (!mToggle) mPtr = {1'b0, d[5:0], 8'h00};
        else mPtr[7:0] = mPtr[7:0] | d;
        mToggle = !mToggle;
      end
      3'd7: mPtr = stepPtr(mPtr, mCtrl);
      default: ;
    endcase
  endtask

  task automatic rdReg(input logic [2:0] s, input bit withSet);
    logic [15:0] m;
    regSel = s; regCs = 1; regRd = 1; vblankSet = withSet;
    #1;
    case (s)
      3'd2: chk("R10 status read value", regRdata, {mVbl, sprZeroHit, sprOverflow, 5'b0});
      3'd4: chk("R12 sprite read data", regRdata, mOam ^ 8'hA5);
      3'd7: begin
        m = expMap(mPtr, mirrorMode);
        chk("R12 data read value", regRdata, expMem(m));
        chk("R7 memSel on data read", memSel, m[15:14]);
      end
      default: chk("R2 write-only slot reads 0", regRdata, 0);
    endcase
    finishCycle();
    if (s == 3'd2) begin mVbl = 0; mToggle = 0; end
    if (s == 3'd7) mPtr = stepPtr(mPtr, mCtrl);
    if (withSet) mVbl = 1;
  endtask

  task automatic checkState(input string tag);
    chk({"R3/R4/R6 pointer ", tag}, vramPtr, mPtr);
    chk({"R3 fineX ", tag}, fineX, mFineX);
    chk({"R11 sprite address ", tag}, oamAddr, mOam);
    chk({"R2 control ", tag}, ctrlOut, mCtrl);
    chk({"R2 mask ", tag}, maskOut, mMask);
  endtask

  task automatic setPtr(input logic [13:0] p);
    rdReg(3'd2, 0);
    wrReg(3'd6, {2'b00, p[13:8]});
    wrReg(3'd6, p[7:0]);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkState("in reset R1");
    chk("R1 status in reset", regRdata, 0);
    rst = 0;
    @(negedge clk);
    checkState("after reset R1");
    rdReg(3'd2, 0);

    // R2: writes without chip select do nothing
    regSel = 3'd0; regWdata = 8'hFF; regWr = 1; regCs = 0;
    finishCycle();
    chk("R2 no effect without chip select", ctrlOut, 0);

    // R6 wrap at top, step 1 and 32
    wrReg(3'd0, 8'h00);
    setPtr(14'h3FFF);
    wrReg(3'd7, 8'h12);
    chk("R6 wrap step 1", vramPtr, 0);
    wrReg(3'd0, 8'h04);
    setPtr(14'h3FF0);
    rdReg(3'd7, 0);
    chk("R6 wrap step 32", vramPtr, 15'h0010);

    // R9 palette alias entries
    wrReg(3'd0, 8'h00);
    for (int i = 0; i < 32; i++) begin
      setPtr(14'h3F00 + 14'(i));
      rdReg(3'd7, 0);
    end
    setPtr(14'h3F10);
    #1 chk("R9 entry 0x10 aliases 0x00", memAddr, 0);
    setPtr(14'h3F14);
    #1 chk("R9 entry 0x14 aliases 0x04", memAddr, 4);
    setPtr(14'h3F15);
    #1 chk("R9 entry 0x15 kept", memAddr, 'h15);

    // R8 each mode at a fixed nametable address
    for (int md = 0; md < 8; md++) begin
      mirrorMode = 3'(md);
      setPtr(14'h2C05);
      #1 chk("R8 mirror mode map", memAddr, expMap(15'h2C05, 3'(md)) & 16'h3FFF);
    end
    mirrorMode = 3'd0;
    setPtr(14'h2C05);
    #1 chk("R8 horizontal table 3", memAddr, 14'h0405);

    // R10 set priority over status read, and clear
    rdReg(3'd2, 1);
    rdReg(3'd2, 0);
    rdReg(3'd2, 0);
    vblankSet = 1; finishCycle(); mVbl = 1;
    vblankClr = 1; finishCycle(); mVbl = 0;
    rdReg(3'd2, 0);

    // R11 sprite address wrap
    wrReg(3'd3, 8'hFF);
    wrReg(3'd4, 8'h33);
    chk("R11 sprite address wraps", oamAddr, 0);
    rdReg(3'd4, 0);
    checkState("directed end");

    // random mix
    for (int it = 0; it < 4000; it++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom % 12);
      d = 8'($urandom);
      mirrorMode = 3'($urandom % 8);
      sprZeroHit = 1'($urandom);
      sprOverflow = 1'($urandom);
      case (op)
        0: wrReg(3'd0, d);
        1: wrReg(3'd1, d);
        2: rdReg(3'd2, ($urandom % 4) == 0);
        3: wrReg(3'd3, d);
        4: wrReg(3'd4, d);
        5: rdReg(3'd4, 0);
        6: wrReg(3'd5, d);
        7: wrReg(3'd6, d);
        8: wrReg(3'd7, d);
        9: rdReg(3'd7, 0);
        10: rdReg(3'(($urandom % 2) == 0 ? 0 : 5), 0);
        default: begin
          if (($urandom % 2) == 0) begin vblankSet = 1; finishCycle(); mVbl = 1; end
          else begin vblankClr = 1; finishCycle(); mVbl = 0; end
        end
      endcase
      checkState("random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule